// File: doc/BRIEF.md
# Transport Stream Capture Buffer Controller

This block sits behind a packet filter and stores the transport-stream packets it accepts into a ring of memory slots. Each packet is 188 bytes long. Bytes arrive one per cycle, with a start-of-packet marker on the first byte. The block packs them into 32-bit words and writes each word through a plain memory write port. The buffer holds eight packet slots, placed one after another from a programmable base address.

Software drives the block through two 32-bit registers. The base register sets where the buffer starts, and writing it restarts the fill. The control/status register does several jobs:
- reports how many whole packets are stored;
- holds two sticky pending flags, one for the fill threshold being reached and one for a packet lost to a full buffer;
- holds four interrupt masks and a packet-count threshold;
- holds an active-low run bit that halts and clears the capture logic;
- accepts a write-one acknowledge that clears the pending flags.

Two level inputs, tuner lock and an almost-full indication, are shown as read-only status and can also raise the single level interrupt line.

Top module: `ts_capture_ctrl`

## Requirements
- R1: After reset, the control word at offset 0x24 reads count 0, pending flags 0, run bit 15 at 0, mask bits 17/14/13/12 all set and threshold bits 6:0 equal to 4. The base at offset 0x20 reads 0, `irq` is low and no memory write occurs.
- R2: While run bit 15 is 0, incoming bytes cause no memory write and the count stays 0. Clearing bit 15 at any time also returns the count to 0 (restart).
- R3: An accepted packet's bytes are packed little-end first: byte 4k+j goes to bits 8j+7:8j of word k. Word k of slot p is written to base + 188·p + 4·k. The write appears on the port in the cycle after the edge that takes the word's fourth byte.
- R4: Count bits 31:24 increase by one when the 188th byte of a packet is taken. The count never exceeds 8.
- R5: Done flag bit 16 is set when the count steps onto the threshold in bits 6:0. A threshold of 0 never sets it, and counts past the threshold do not set it again.
- R6: A start-of-packet that arrives while 8 packets are stored sets overflow flag bit 11. That packet is dropped whole, with no memory write.
- R7: A control write with bit 8 set clears both pending flags. A control write with bit 8 clear leaves them unchanged.
- R8: `irq` is high while any of these holds: done pending with mask 17 clear; overflow pending with mask 14 clear; `afull_in` high with mask 13 clear; `lock_in` high with mask 12 clear. Bits 10 and 9 read `afull_in` and `lock_in`.
- R9: A write to offset 0x20 stores the base with bits 1:0 forced to 0 and restarts the buffer. The count goes to 0, a packet in flight is discarded up to the next start marker, and the next packet goes to the new base.
- R10: A start marker in the middle of a packet abandons the partial packet. The new packet is written from word 0 of the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| in_valid | input | 1 | Filtered byte valid |
| in_sop | input | 1 | First byte of a packet |
| in_data | input | 8 | Filtered byte |
| lock_in | input | 1 | Lock status level |
| afull_in | input | 1 | Almost-full status level |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Memory word data |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a start marker that meets a completely full buffer. Reaching it takes eight whole packets, 1504 cycles of bytes, with no restart in between. The bench reaches it both directly and in random rounds that send up to eleven packets against a random threshold and base. The same rounds mix in partial packets cut short by a new start marker, and stray bytes with no marker, so that restarts within a slot and ignored bytes also occur far from reset.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned RA_W       = 6;

    localparam logic [RA_W-1:0] OFS_BASE = 6'h20;
    localparam logic [RA_W-1:0] OFS_CTRL = 6'h24;

    // control word bit positions (software contract)
    localparam int unsigned B_MDONE = 17;
    localparam int unsigned B_PDONE = 16;
    localparam int unsigned B_RUN   = 15;
    localparam int unsigned B_MOVR  = 14;
    localparam int unsigned B_MAFL  = 13;
    localparam int unsigned B_MLCK  = 12;
    localparam int unsigned B_POVR  = 11;
    localparam int unsigned B_AFL   = 10;
    localparam int unsigned B_LCK   = 9;
    localparam int unsigned B_ACK   = 8;
    localparam int unsigned THR_W   = 7;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_CAPT = 2'd1,
        PK_DROP = 2'd2
    } pk_mode_e;

endpackage

// File: rtl/ts_cap_regs.sv
module ts_cap_regs
    import ts_cap_pkg::*;
#(
    parameter int unsigned THR_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lock_in,
    input  logic              afull_in,
    input  logic [7:0]        pkt_cnt,
    input  logic              done_evt,
    input  logic              ovr_evt,
    output logic [31:0]       base_o,
    output logic              run_o,
    output logic [THR_W-1:0]  thr_o,
    output logic              restart_o,
    output logic [3:0]        mask_o,
    output logic [1:0]        pend_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [31:0]      base;
        logic             run;
        logic             m_done;
        logic             m_ovr;
        logic             m_afl;
        logic             m_lck;
        logic             p_done;
        logic             p_ovr;
        logic [THR_W-1:0] thr;
    } regs_t;

    regs_t r_d, r_q;
    logic  base_wr, ctrl_wr, ack;

    always_comb begin
        r_d     = r_q;
        base_wr = reg_we && (reg_addr == OFS_BASE);
        ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
        ack     = ctrl_wr && reg_wdata[B_ACK];

        if (base_wr) begin
            r_d.base = {reg_wdata[31:2], 2'b00};
        end
        if (ctrl_wr) begin
            r_d.run    = reg_wdata[B_RUN];
            r_d.m_done = reg_wdata[B_MDONE];
            r_d.m_ovr  = reg_wdata[B_MOVR];
            r_d.m_afl  = reg_wdata[B_MAFL];
            r_d.m_lck  = reg_wdata[B_MLCK];
            r_d.thr    = reg_wdata[THR_W-1:0];
        end
        // a new event in the acknowledge cycle is kept
        r_d.p_done = done_evt | (r_q.p_done & ~ack);
        r_d.p_ovr  = ovr_evt  | (r_q.p_ovr  & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.m_done <= 1'b1;
            r_q.m_ovr  <= 1'b1;
            r_q.m_afl  <= 1'b1;
            r_q.m_lck  <= 1'b1;
            r_q.thr    <= THR_W'(THR_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_BASE: reg_rdata = r_q.base;
            OFS_CTRL: begin
                reg_rdata[31:24]       = pkt_cnt;
                reg_rdata[B_MDONE]     = r_q.m_done;
                reg_rdata[B_PDONE]     = r_q.p_done;
                reg_rdata[B_RUN]       = r_q.run;
                reg_rdata[B_MOVR]      = r_q.m_ovr;
                reg_rdata[B_MAFL]      = r_q.m_afl;
                reg_rdata[B_MLCK]      = r_q.m_lck;
                reg_rdata[B_POVR]      = r_q.p_ovr;
                reg_rdata[B_AFL]       = afull_in;
                reg_rdata[B_LCK]       = lock_in;
                reg_rdata[THR_W-1:0]   = r_q.thr;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign base_o    = r_q.base;
    assign run_o     = r_q.run;
    assign thr_o     = r_q.thr;
    assign restart_o = base_wr;
    assign mask_o    = {r_q.m_done, r_q.m_ovr, r_q.m_afl, r_q.m_lck};
    assign pend_o    = {r_q.p_done, r_q.p_ovr};
    assign irq_o     = (r_q.p_done & ~r_q.m_done) | (r_q.p_ovr & ~r_q.m_ovr)
                     | (afull_in & ~r_q.m_afl)    | (lock_in & ~r_q.m_lck);

endmodule

// File: rtl/ts_cap_packer.sv
module ts_cap_packer
    import ts_cap_pkg::*;
#(
    parameter int unsigned PKT_BYTES = 188,
    parameter int unsigned PKTS      = 8,
    localparam int unsigned BIDX_W   = $clog2(PKT_BYTES),
    localparam int unsigned CNT_W    = $clog2(PKTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [31:0]       base,
    input  logic [THR_W-1:0]  thr,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [CNT_W-1:0]  pkt_count,
    output logic              done_evt,
    output logic              ovr_evt
);

    typedef struct packed {
        pk_mode_e          mode;
        logic [BIDX_W-1:0] bidx;
        logic [CNT_W-1:0]  cnt;
        logic [31:0]       wbuf;
        logic              we;
        logic [31:0]       addr;
        logic [31:0]       wdata;
    } pk_t;

    pk_t               s_d, s_q;
    logic              take;
    logic [BIDX_W-1:0] idx;
    logic [1:0]        lane;
    logic [31:0]       word;
    logic [31:0]       offs;

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        done_evt = 1'b0;
        ovr_evt  = 1'b0;
        take     = 1'b0;
        idx      = s_q.bidx;
        lane     = 2'd0;
        word     = s_q.wbuf;
        offs     = '0;

        if (!run || restart) begin
            s_d.mode = PK_IDLE;
            s_d.bidx = '0;
            s_d.cnt  = '0;
            s_d.wbuf = '0;
        end else if (in_valid) begin
            if (in_sop) begin
                if (s_q.cnt == CNT_W'(PKTS)) begin
                    ovr_evt  = 1'b1;
                    s_d.mode = PK_DROP;
                end else begin
                    take = 1'b1;
                    idx  = '0;
                end
            end else begin
                take = (s_q.mode == PK_CAPT);
            end

            if (take) begin
                lane                  = idx[1:0];
                word[{lane, 3'b000} +: 8] = in_data;
                s_d.wbuf              = word;
                s_d.mode              = PK_CAPT;
                offs = 32'(s_q.cnt) * 32'(PKT_BYTES) + (32'(idx) & ~32'd3);
                if (lane == 2'd3) begin
                    s_d.we    = 1'b1;
                    s_d.addr  = base + offs;
                    s_d.wdata = word;
                end
                if (idx == BIDX_W'(PKT_BYTES - 1)) begin
                    s_d.cnt  = s_q.cnt + 1'b1;
                    s_d.mode = PK_IDLE;
                    s_d.bidx = '0;
                    done_evt = (thr != '0) && ((32'(s_q.cnt) + 32'd1) == 32'(thr));
                end else begin
                    s_d.bidx = idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= PK_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we    = s_q.we;
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.wdata;
    assign pkt_count = s_q.cnt;

endmodule

// File: rtl/ts_capture_ctrl.sv
module ts_capture_ctrl
    import ts_cap_pkg::*;
#(
    parameter int unsigned PKT_BYTES = 188,
    parameter int unsigned PKTS      = 8,
    parameter int unsigned THR_RESET = PKTS / 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [7:0]  in_data,
    input  logic        lock_in,
    input  logic        afull_in,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        irq
);

    localparam int unsigned CNT_W = $clog2(PKTS + 1);

    logic [31:0]      base_w;
    logic             run_w;
    logic [THR_W-1:0] thr_w;
    logic             restart_w;
    logic [3:0]       mask_w;
    logic [1:0]       pend_w;
    logic [CNT_W-1:0] cnt_w;
    logic [7:0]       cnt8_w;
    logic             done_evt_w;
    logic             ovr_evt_w;

    generate
        if (CNT_W < 8) begin : g_cnt_pad
            assign cnt8_w = {{(8 - CNT_W){1'b0}}, cnt_w};
        end else begin : g_cnt_cut
            assign cnt8_w = cnt_w[7:0];
        end
    endgenerate

    ts_cap_regs #(
        .THR_RESET (THR_RESET)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lock_in   (lock_in),
        .afull_in  (afull_in),
        .pkt_cnt   (cnt8_w),
        .done_evt  (done_evt_w),
        .ovr_evt   (ovr_evt_w),
        .base_o    (base_w),
        .run_o     (run_w),
        .thr_o     (thr_w),
        .restart_o (restart_w),
        .mask_o    (mask_w),
        .pend_o    (pend_w),
        .irq_o     (irq)
    );

    ts_cap_packer #(
        .PKT_BYTES (PKT_BYTES),
        .PKTS      (PKTS)
    ) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .restart   (restart_w),
        .base      (base_w),
        .thr       (thr_w),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_data   (in_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pkt_count (cnt_w),
        .done_evt  (done_evt_w),
        .ovr_evt   (ovr_evt_w)
    );

endmodule

// File: rtl/ts_capture_ctrl_chk.sv
module ts_capture_ctrl_chk #(
    parameter int unsigned PKT_BYTES = 188,
    parameter int unsigned PKTS      = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        in_valid,
    input logic        in_sop,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] base_w,
    input logic        run_w,
    input logic        restart_w,
    input logic [7:0]  cnt8_w,
    input logic [3:0]  mask_w,
    input logic [1:0]  pend_w,
    input logic        done_evt_w,
    input logic        irq
);

    localparam logic [31:0] SPAN = 32'(PKTS * PKT_BYTES);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt8_w) <= 32'(PKTS));

    // R3
    wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr - base_w) < SPAN) && (mem_addr[1:0] == 2'b00));

    // R2
    halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w |=> !mem_we);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !restart_w && in_valid && in_sop && (32'(cnt8_w) == 32'(PKTS)))
        |=> (pend_w[0] && !mem_we));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 6'h24 && reg_wdata[8] && !done_evt_w) |=> !pend_w[1]);

    // R9
    base_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 6'h20) |=> (cnt8_w == 8'd0));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_w) |-> !irq);

endmodule

bind ts_capture_ctrl ts_capture_ctrl_chk #(
    .PKT_BYTES (PKT_BYTES),
    .PKTS      (PKTS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .base_w     (base_w),
    .run_w      (run_w),
    .restart_w  (restart_w),
    .cnt8_w     (cnt8_w),
    .mask_w     (mask_w),
    .pend_w     (pend_w),
    .done_evt_w (done_evt_w),
    .irq        (irq)
);

// File: tb/test_ts_capture_ctrl.sv
module test_ts_capture_ctrl;

    localparam int PKT_BYTES = 188;
    localparam int PKTS      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        lock_in = 1'b0;
    logic        afull_in = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        irq;

    always #10 clk = ~clk;

    ts_capture_ctrl i_ts_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_sop(in_sop), .in_data(in_data), .lock_in(lock_in), .afull_in(afull_in),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [31:0] m_base = '0;
    bit          m_run = 0;
    int          m_cnt = 0;
    int          m_mode = 0;   // 0 idle, 1 capture, 2 drop
    int          m_bidx = 0;
    bit          m_done = 0, m_ovr = 0;
    int          m_thr = 4;
    bit [3:0]    m_mask = 4'hF; // done, ovr, afull, lock
    logic [31:0] m_acc = '0;
    logic [63:0] exp_q[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_irq();
        return (m_done & ~m_mask[3]) | (m_ovr & ~m_mask[2]) |
               (afull_in & ~m_mask[1]) | (lock_in & ~m_mask[0]);
    endfunction

    // write monitor: every port write must match the next expected word (R3)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R2/R6 unexpected write", {mem_addr, mem_wdata}, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R3 write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic reg_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr_base(input logic [31:0] b);
        reg_write(6'h20, b);
        m_base = {b[31:2], 2'b00};
        m_cnt = 0; m_mode = 0; m_bidx = 0;
    endtask

    task automatic wr_ctrl(input bit run, input bit [3:0] mask, input bit ack, input int thr);
        logic [31:0] v;
        v = '0;
        v[17] = mask[3]; v[14] = mask[2]; v[13] = mask[1]; v[12] = mask[0];
        v[15] = run; v[8] = ack; v[6:0] = 7'(thr);
        reg_write(6'h24, v);
        m_run = run; m_mask = mask; m_thr = thr;
        if (ack) begin m_done = 0; m_ovr = 0; end
        if (!run) begin m_cnt = 0; m_mode = 0; m_bidx = 0; end
    endtask

    task automatic drive_byte(input bit sop, input logic [7:0] d);
        bit take;
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_data = d;
        take = 0;
        if (m_run) begin
            if (sop) begin
                if (m_cnt == PKTS) begin m_ovr = 1; m_mode = 2; end
                else begin take = 1; m_bidx = 0; end
            end else begin
                take = (m_mode == 1);
            end
            if (take) begin
                m_mode = 1;
                m_acc[8*(m_bidx%4) +: 8] = d;
                if (m_bidx % 4 == 3)
                    exp_q.push_back({m_base + 32'(m_cnt*PKT_BYTES + (m_bidx & ~3)), m_acc});
                if (m_bidx == PKT_BYTES-1) begin
                    m_cnt++; m_mode = 0; m_bidx = 0;
                    if (m_thr != 0 && m_cnt == m_thr) m_done = 1;
                end else begin
                    m_bidx++;
                end
            end
        end
    endtask

    task automatic send(input int n, input bit with_sop);
        for (int i = 0; i < n; i++) drive_byte(with_sop && i == 0, 8'($urandom_range(0, 255)));
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic check_status(input string req);
        logic [31:0] v;
        reg_read(6'h24, v);
        check(v[31:24] == 8'(m_cnt), {req, " count"}, v[31:24], m_cnt);
        check(v[16] == m_done, {req, " done flag"}, v[16], m_done);
        check(v[11] == m_ovr, {req, " overflow flag"}, v[11], m_ovr);
        #1 check(irq == exp_irq(), {req, " irq"}, irq, exp_irq());
    endtask

    initial begin
        #(20 * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(6'h24, v);
        check(v == 32'h0002_7004, "R1 control reset value", v, 32'h0002_7004);
        reg_read(6'h20, v);
        check(v == 32'h0, "R1 base reset value", v, 0);
        check(irq == 1'b0, "R1 irq low", irq, 0);

        // R2 halted: bytes ignored
        send(PKT_BYTES, 1);
        check_status("R2 halted");

        // R9 low bits of base forced to zero
        wr_base(32'h1000_0003);
        reg_read(6'h20, v);
        check(v == 32'h1000_0000, "R9 base alignment", v, 32'h1000_0000);

        // R5 threshold 4, done/overflow unmasked
        wr_ctrl(1, 4'b0011, 1, 4);
        for (int p = 0; p < 3; p++) send(PKT_BYTES, 1);
        check_status("R5 below threshold");
        send(PKT_BYTES, 1);
        check_status("R5 R8 threshold reached");
        wr_ctrl(1, 4'b0011, 1, 4);
        check_status("R7 acknowledge");
        for (int p = 0; p < 4; p++) send(PKT_BYTES, 1);
        check_status("R4 R5 full, no retrigger");

        // R6 overflow drop, R4 saturation
        send(PKT_BYTES, 1);
        check_status("R6 R4 overflow");
        wr_ctrl(1, 4'b0011, 0, 4);
        check_status("R7 write without ack");
        wr_ctrl(1, 4'b0111, 0, 4);
        check_status("R8 overflow masked");
        wr_ctrl(1, 4'b0011, 1, 4);

        // R8 lock and almost-full
        lock_in = 1'b1;
        check_status("R8 lock masked");
        wr_ctrl(1, 4'b0010, 0, 4);
        check_status("R8 lock unmasked");
        reg_read(6'h24, v);
        check(v[9] == 1'b1 && v[10] == 1'b0, "R8 status bits", v[10:9], 2'b01);
        lock_in = 1'b0; afull_in = 1'b1;
        wr_ctrl(1, 4'b0001, 0, 4);
        check_status("R8 almost-full unmasked");
        afull_in = 1'b0;
        wr_ctrl(1, 4'b0011, 1, 4);

        // R9 restart mid-packet
        wr_base(32'h2000_0100);
        send(100, 1);
        wr_base(32'h3000_0000);
        send(40, 0);
        send(PKT_BYTES, 1);
        check_status("R9 restart");

        // R10 start marker mid-packet
        send(50, 1);
        send(PKT_BYTES, 1);
        check_status("R10 resync");

        // R2 clearing run returns count to zero
        wr_ctrl(0, 4'b0011, 0, 4);
        check_status("R2 run cleared");
        send(PKT_BYTES, 1);
        check_status("R2 halted again");

        // random rounds
        for (int r = 0; r < 12; r++) begin
            int thr, npk;
            thr = $urandom_range(0, 8);
            wr_base($urandom);
            wr_ctrl(1, 4'b0011, 1, thr);
            npk = $urandom_range(0, 11);
            for (int p = 0; p < npk; p++) begin
                if ($urandom_range(0, 4) == 0) send($urandom_range(1, PKT_BYTES - 1), 1);
                if ($urandom_range(0, 5) == 0) send($urandom_range(1, 20), 0);
                send(PKT_BYTES, 1);
            end
            check_status("R3 R4 R5 R6 random round");
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 missing writes", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule